// File: doc/BRIEF.md
# Overlapping frame buffer

This block is a dual-clock sample store placed in front of a block-transform engine that cannot buffer its own input. Samples arrive one at a time in the sample clock domain and are kept in a 1024-entry, 32-bit store. When the store holds a complete frame, the block raises a ready flag in the system clock domain. The engine then pulls the frame by holding a read enable, and receives it at one word per system clock.

Consecutive frames overlap. The overlap is programmed as a count `k` of 32-word units, so the overlap is 32·k words. When a frame finishes, the next frame begins 1024 − 32·k words after the start of the one just sent. The overlapped words are read again from the store, so the engine keeps no history. With k = 16 the overlap is half a frame, and with k = 24 it is three quarters. Any other k from 0 to 31 also works.

The ready flag, the read sequencing and overrun protection are all generated inside the block. No outside control logic is needed.

Top module: `ovl_frame_buf`

## Requirements
- R1: While reset is held and right after it, `frame_rdy`, `rd_valid`, `rd_last` and `overrun` are all 0.
- R2: After reset, `frame_rdy` stays 0 until 1024 samples have been accepted. It rises once the 1024th sample has crossed into the system domain.
- R3: While `rd_en` is held high, a frame appears as exactly 1024 consecutive cycles of `rd_valid`. `rd_last` is high on word 1023 only. `frame_rdy` is 0 while a frame is being sent.
- R4: Word i of a frame is the sample accepted at position start+i, counting accepted samples in write order. The first frame starts at 0. Each later frame starts 1024 − 32·k after the previous one, where k is the value of `ovl_k` in the cycle that carries word 1023.
- R5: After a frame sent with k = 16, the next frame becomes ready only once 512 new samples have arrived. After a frame sent with k = 24, it needs 256 new samples.
- R6: Any k from 0 to 31 works. k = 0 needs 1024 new samples, k = 31 needs 32 new samples and k = 8 needs 768 new samples.
- R7: Taking `rd_en` low during a frame pauses it, and `rd_valid` goes low. Raising `rd_en` again resumes the frame with the next word in order.
- R8: A sample is dropped when 1024 written samples are still held, counted from the start of the oldest frame not yet fully read. A dropped sample is never delivered, and it sets `overrun`, which then stays high until reset.
- R9: `rd_valid` is high only in the cycle after a cycle in which `rd_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Sample clock |
| sclk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Sample strobe (wclk) |
| wr_data | input | 32 | Sample word (wclk) |
| ovl_k | input | 5 | Overlap in 32-word units (sclk) |
| rd_en | input | 1 | Engine read enable (sclk) |
| frame_rdy | output | 1 | A full frame is waiting (sclk) |
| rd_valid | output | 1 | rd_data carries a frame word (sclk) |
| rd_data | output | 32 | Frame word (sclk) |
| rd_last | output | 1 | Marks word 1023 of a frame (sclk) |
| overrun | output | 1 | Sticky: a sample was dropped (wclk) |

## Verification
The assertions take for granted three things about the inputs. Reset is asserted at time zero and released in both domains together. `rd_en` carries a known value in every system clock cycle. A frame is read to its last word before it is judged, because the word counter in the checker assumes that frames are never abandoned.

The stimulus keeps within these limits. It drives `rd_en` to 0 from time zero, raises it only when `frame_rdy` is high, and holds it for exactly as many accepted cycles as a frame has words. It also holds `ovl_k` constant across each frame.

The overrun case is entered only after waiting long enough for the released space to reach the write side. This way the drops the bench expects are exactly the ones the block makes.

// File: rtl/ovl_frame_buf.sv
module ovl_frame_buf #(
  parameter int DW = 32,
  parameter int AW = 10,
  parameter int UW = 5,
  parameter int KW = 5
) (
  input  logic          wclk,
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [KW-1:0] ovl_k,
  input  logic          rd_en,
  output logic          frame_rdy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic          overrun
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2;
  logic [PW-1:0] wg_s1, wg_s2;
  logic [PW-1:0] fstart, rel, relg;
  logic [AW-1:0] cnt;
  logic          busy;

  wire [PW-1:0] rel_w = g2b(rg_s2);
  wire [PW-1:0] wdiff = wbin - rel_w;
  wire          wfull = wdiff[AW];

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      rg_s1   <= '0;
      rg_s2   <= '0;
      overrun <= 1'b0;
    end else begin
      rg_s1 <= relg;
      rg_s2 <= rg_s1;
      if (wr_en) begin
        if (wfull) overrun <= 1'b1;
        else begin
          wbin  <= wbin + 1'b1;
          wgray <= b2g(wbin + 1'b1);
        end
      end
    end

  always_ff @(posedge wclk)
    if (wr_en && !wfull) mem[wbin[AW-1:0]] <= wr_data;

  wire [PW-1:0] wsync = g2b(wg_s2);
  wire [PW-1:0] avail = wsync - fstart;
  wire          rdy   = avail[AW];
  wire          fire  = rd_en & (busy | rdy);
  wire          endw  = fire & (&cnt);
  wire [PW-1:0] step  = PW'(DEPTH) - (PW'(ovl_k) << UW);
  wire [AW-1:0] raddr = fstart[AW-1:0] + cnt;

  assign frame_rdy = rdy & ~busy;

  always_ff @(posedge sclk or negedge rst_n)
    if (!rst_n) begin
      wg_s1    <= '0;
      wg_s2    <= '0;
      fstart   <= '0;
      rel      <= '0;
      relg     <= '0;
      cnt      <= '0;
      busy     <= 1'b0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      wg_s1    <= wgray;
      wg_s2    <= wg_s1;
      rd_valid <= fire;
      rd_last  <= endw;
      if (fire) begin
        cnt  <= cnt + 1'b1;
        busy <= ~(&cnt);
      end
      if (endw) fstart <= fstart + step;
      if (rel != fstart) begin
        rel  <= rel + 1'b1;
        relg <= b2g(rel + 1'b1);
      end
    end

  always_ff @(posedge sclk)
    if (fire) rd_data <= mem[raddr];

endmodule

module ovl_frame_buf_chk #(
  parameter int AW = 10
) (
  input logic wclk,
  input logic sclk,
  input logic rst_n,
  input logic rd_en,
  input logic frame_rdy,
  input logic rd_valid,
  input logic rd_last,
  input logic overrun
);
  localparam int DEPTH = 1 << AW;
  logic [AW-1:0] wcnt;

  always_ff @(posedge sclk or negedge rst_n)
    if (!rst_n) wcnt <= '0;
    else if (rd_valid) wcnt <= wcnt + 1'b1;

  // R3
  last_pos_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    rd_valid |-> (rd_last == (int'(wcnt) == DEPTH - 1)));

  // R3
  last_valid_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  // R9
  valid_after_en_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

  // R2
  start_needs_rdy_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (rd_valid && wcnt == '0) |-> $past(frame_rdy));

  // R8
  overrun_sticky_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind ovl_frame_buf ovl_frame_buf_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .sclk(sclk), .rst_n(rst_n), .rd_en(rd_en),
  .frame_rdy(frame_rdy), .rd_valid(rd_valid), .rd_last(rd_last),
  .overrun(overrun)
);

// File: tb/sim_ovl_frame_buf.sv
module sim_ovl_frame_buf;
  localparam int CLK_PERIOD = 10;
  localparam int WCLK_PERIOD = 26;
  localparam int N = 1024;

  logic wclk = 0, sclk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = '0;
  logic [4:0] ovl_k = '0;
  logic frame_rdy, rd_valid, rd_last, overrun;
  logic [31:0] rd_data;

  ovl_frame_buf u0 (
    .wclk(wclk), .sclk(sclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ovl_k(ovl_k), .rd_en(rd_en), .frame_rdy(frame_rdy), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_last(rd_last), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) sclk = ~sclk;
  always #(WCLK_PERIOD/2) wclk = ~wclk;

  int tests = 0, fails = 0;
  int acc = 0, bstart = 0;
  int run_len = 0, last_run = 0;
  string cur_req = "R4";
  logic [32:0] exp_q[$];

  function automatic logic [31:0] val(int n);
    return (n * 32'd65539) ^ 32'h3C00_0000;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_n(int n, bit drop);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en = 1;
      wr_data = drop ? (32'hDEAD_0000 + i) : val(acc);
      if (!drop) acc++;
    end
    @(negedge wclk);
    wr_en = 0;
    repeat (10) @(negedge sclk);
  endtask

  task automatic push_frame();
    for (int i = 0; i < N; i++)
      exp_q.push_back({(i == N - 1), val(bstart + i)});
  endtask

  task automatic read_frame(int k, int pause_at, string req);
    ovl_k = k;
    cur_req = req;
    push_frame();
    @(negedge sclk);
    rd_en = 1;
    for (int i = 0; i < N; i++) begin
      if (i == pause_at) begin
        rd_en = 0;
        repeat (4) @(negedge sclk);
        chk(rd_valid == 0, "R7", "valid while paused", rd_valid, 0);
        chk(rd_valid == 0, "R9", "valid without enable", rd_valid, 0);
        rd_en = 1;
      end
      @(negedge sclk);
      if (i == 10) chk(frame_rdy == 0, "R3", "rdy during burst", frame_rdy, 0);
    end
    rd_en = 0;
    repeat (4) @(negedge sclk);
    chk(exp_q.size() == 0, req, "words left undelivered", exp_q.size(), 0);
    if (pause_at < 0) chk(last_run == N, "R3", "valid run length", last_run, N);
    bstart += N - 32 * k;
  endtask

  task automatic need(int n, string req);
    write_n(n - 1, 0);
    chk(frame_rdy == 0, req, "rdy one sample short", frame_rdy, 0);
    write_n(1, 0);
    chk(frame_rdy == 1, req, "rdy after enough samples", frame_rdy, 1);
  endtask

  always @(negedge sclk) begin
    if (rd_valid) begin
      run_len++;
      if (exp_q.size() == 0)
        chk(0, cur_req, "unexpected word", rd_data, 0);
      else begin
        logic [32:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e[31:0], cur_req, "frame word", rd_data, e[31:0]);
        chk(rd_last == e[32], "R3", "last strobe", rd_last, e[32]);
      end
    end else if (run_len != 0) begin
      last_run = run_len;
      run_len = 0;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge sclk);
    chk(frame_rdy == 0, "R1", "frame_rdy in reset", frame_rdy, 0);
    chk(rd_valid == 0, "R1", "rd_valid in reset", rd_valid, 0);
    chk(overrun == 0, "R1", "overrun in reset", overrun, 0);
    rst_n = 1;
    repeat (3) @(negedge sclk);
    chk(rd_last == 0, "R1", "rd_last after reset", rd_last, 0);
    chk(frame_rdy == 0, "R1", "frame_rdy after reset", frame_rdy, 0);

    need(N, "R2");
    read_frame(16, -1, "R4");
    need(512, "R5");
    read_frame(24, 300, "R7");
    need(256, "R5");
    read_frame(0, -1, "R4");
    need(1024, "R6");
    read_frame(31, -1, "R6");
    need(32, "R6");

    repeat (1100) @(negedge sclk);
    chk(overrun == 0, "R8", "overrun before drop", overrun, 0);
    write_n(3, 1);
    chk(overrun == 1, "R8", "overrun after drop", overrun, 1);
    read_frame(8, -1, "R8");
    repeat (1100) @(negedge sclk);
    need(768, "R6");
    read_frame(8, -1, "R8");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule